// File: doc/BRIEF.md
# Software-Selectable Condition Evaluator

This block decides whether a conditional instruction should execute. Each cycle it receives the arithmetic status bits produced elsewhere in the datapath, a small group of general-purpose flag inputs and a 4-bit condition selector taken from the instruction. It answers with a single condition-true bit. Most selector values name a fixed test that maps straight onto the status bits. The selector values are grouped in pairs, and the odd member of each pair is the negation of the even member.

Two selector values do not name a fixed test. They evaluate whatever test a writable condition-code register currently holds, one in true polarity and one inverted. This is the only way to reach the shifter-overflow bit, the sign bit and the flag inputs, because none of these has a direct selector value. A write to the condition-code register is registered, so the new code is seen by evaluation from the cycle after the write. During the write cycle the previous code still applies. The output is combinational from the selector, status and flags, so a condition can be resolved in the same cycle in which it is asked.

Top module: `cond_eval_top`

## Requirements
- R1: Selector value 15 always yields true. While `rst` is high, the output is 1 whatever the selector, status and flags are.
- R2: Selector 0 yields status bit 0 (ALU zero). Selector 1 yields its complement.
- R3: Selector 4 (less than) yields status bit 1 (ALU negative) XOR status bit 2 (ALU overflow). Selector 5 (greater or equal) yields its complement.
- R4: Selector 2 (greater than) is true when bit 0 is clear and the less-than term of R3 is false. Selector 3 (less or equal) yields its complement.
- R5: Selectors 6, 8 and 10 yield status bit 2 (ALU overflow), bit 3 (ALU carry) and bit 4 (multiplier overflow) respectively. Selectors 7, 9 and 11 yield the complements of those three tests.
- R6: Selector 14 always yields false.
- R7: Selector 12 yields the test chosen by the condition-code register. Selector 13 yields the complement of that test.
- R8: When `cc_we` is high, `cc_wdata` is stored at the next clock edge. Evaluation in the write cycle uses the old code, and evaluation from the following cycle uses the new code.
- R9: Code 0x09 tests status bit 5 (shifter overflow, 1 on overflow or underflow). Code 0x0A tests its complement.
- R10: Code 0x03+i tests flag input i, for i from 0 to NFLAG-1. With the default NFLAG of 4, this covers codes 0x03 to 0x06.
- R11: Code 0x01 tests status bit 6 (ALU sign), true when the bit is set. Code 0x02 is true when the bit is clear.
- R12: The condition-code register holds 0x00 after reset, and a write presented while `rst` is high is discarded. Any code not assigned by R9 to R11, including 0x00, makes selector 12 false and selector 13 true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_i | input | 7 | Status: [0] zero, [1] negative, [2] overflow, [3] carry, [4] multiplier overflow, [5] shifter overflow, [6] sign |
| flag_i | input | NFLAG | General-purpose flag inputs |
| cc_we | input | 1 | Condition-code register write enable |
| cc_wdata | input | CC_W | Condition-code value to write |
| cond_sel | input | 4 | Condition selector from the instruction |
| cond_true | output | 1 | Condition result |

## Verification
The bench goes after the write latency of the condition code. In the write cycle it expects the old answer and in the next cycle the new one. A design that bypassed the write data, or one that added a second register stage, would give the wrong value in exactly one of those two cycles. The bench also writes codes back to back and writes during reset, which exposes a register that missed an update or let a reset-time write through. It sweeps all combinations of the negative and overflow bits for the signed compares, so a compare built on the negative bit alone fails once overflow is set. Unassigned codes are checked in both polarities, so a decoder that gave false for both the true and the inverted software condition would be caught.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int SEL_W  = 4;
    localparam int STAT_W = 7;

    // Status word: bit 0 is the least significant field (az).
    typedef struct packed {
        logic sgn;  // [6] ALU sign
        logic sv;   // [5] shifter overflow / underflow
        logic mv;   // [4] multiplier overflow
        logic ac;   // [3] ALU carry
        logic av;   // [2] ALU overflow
        logic an;   // [1] ALU negative
        logic az;   // [0] ALU zero
    } stat_t;

    // Pairs share sel[3:1]; sel[0] selects the inverted polarity.
    typedef enum logic [SEL_W-1:0] {
        SEL_EQ     = 4'd0,
        SEL_NE     = 4'd1,
        SEL_GT     = 4'd2,
        SEL_LE     = 4'd3,
        SEL_LT     = 4'd4,
        SEL_GE     = 4'd5,
        SEL_AV     = 4'd6,
        SEL_NAV    = 4'd7,
        SEL_AC     = 4'd8,
        SEL_NAC    = 4'd9,
        SEL_MV     = 4'd10,
        SEL_NMV    = 4'd11,
        SEL_SW     = 4'd12,
        SEL_NSW    = 4'd13,
        SEL_NEVER  = 4'd14,
        SEL_ALWAYS = 4'd15
    } sel_e;

    // Condition-code assignments for the software condition.
    localparam int CC_SIGN   = 1;
    localparam int CC_NSIGN  = 2;
    localparam int CC_FLAG0  = 3;
    localparam int CC_SV     = 9;
    localparam int CC_NSV    = 10;
    localparam int FLAG_MAX  = CC_SV - CC_FLAG0;

    // Signed less-than from the negative and overflow bits.
    function automatic logic signed_lt(input logic neg, input logic ovf);
        return neg ^ ovf;
    endfunction

endpackage

// File: rtl/cc_reg.sv
module cc_reg #(
    parameter int CC_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [CC_W-1:0] wdata,
    output logic [CC_W-1:0] cc_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cc_q <= '0;
        else if (we)
            cc_q <= wdata;
    end

    // R12: the register reads zero in the first cycle after reset
    a_r12_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cc_q == '0));

endmodule

// File: rtl/swcond_decode.sv
module swcond_decode
    import cond_pkg::*;
#(
    parameter int NFLAG = 4,
    parameter int CC_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CC_W-1:0]  cc_q,
    input  logic             sv,
    input  logic             sgn,
    input  logic [NFLAG-1:0] flag,
    output logic             sw_hit
);

    logic [NFLAG-1:0] flag_match;
    logic             sign_match;
    logic             sv_match;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            assign flag_match[i] = (cc_q == CC_W'(CC_FLAG0 + i)) & flag[i];
        end
    endgenerate

    always_comb begin
        sign_match = 1'b0;
        sv_match   = 1'b0;
        case (cc_q)
            CC_W'(CC_SIGN):  sign_match = sgn;
            CC_W'(CC_NSIGN): sign_match = ~sgn;
            CC_W'(CC_SV):    sv_match   = sv;
            CC_W'(CC_NSV):   sv_match   = ~sv;
            default: begin
                sign_match = 1'b0;
                sv_match   = 1'b0;
            end
        endcase
    end

    assign sw_hit = (|flag_match) | sign_match | sv_match;

    // R9: code 0x09 follows the shifter overflow bit
    a_r9_sv_code: assert property (@(posedge clk) disable iff (rst)
        (cc_q == CC_W'(CC_SV)) |-> (sw_hit == sv));

    // R10: code 0x03 follows flag input 0
    a_r10_flag0_code: assert property (@(posedge clk) disable iff (rst)
        (cc_q == CC_W'(CC_FLAG0)) |-> (sw_hit == flag[0]));

    // R12: the reset code selects no test
    a_r12_zero_code_false: assert property (@(posedge clk) disable iff (rst)
        (cc_q == '0) |-> !sw_hit);

endmodule

// File: rtl/cond_fixed.sv
module cond_fixed
    import cond_pkg::*;
(
    input  logic             az,
    input  logic             an,
    input  logic             av,
    input  logic             ac,
    input  logic             mv,
    input  logic             sw_hit,
    input  logic [SEL_W-1:0] sel,
    output logic             result
);

    localparam int NPAIR = 1 << (SEL_W - 1);

    logic [NPAIR-1:0] base;
    logic             lt;

    always_comb begin
        lt      = signed_lt(an, av);
        base    = '0;
        base[0] = az;             // EQ / NE
        base[1] = ~az & ~lt;      // GT / LE
        base[2] = lt;             // LT / GE
        base[3] = av;             // AV / not AV
        base[4] = ac;             // AC / not AC
        base[5] = mv;             // MV / not MV
        base[6] = sw_hit;         // software / inverse
        base[7] = 1'b0;           // NEVER / ALWAYS
    end

    assign result = base[sel[SEL_W-1:1]] ^ sel[0];

endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
    import cond_pkg::*;
#(
    parameter int NFLAG = 4,
    parameter int CC_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STAT_W-1:0]  stat_i,
    input  logic [NFLAG-1:0]   flag_i,
    input  logic               cc_we,
    input  logic [CC_W-1:0]    cc_wdata,
    input  logic [SEL_W-1:0]   cond_sel,
    output logic               cond_true
);

    stat_t            stat;
    logic [CC_W-1:0]  cc_q;
    logic             sw_hit;
    logic [SEL_W-1:0] sel_eff;

    assign stat    = stat_t'(stat_i);
    assign sel_eff = rst ? SEL_ALWAYS : cond_sel;

    cc_reg #(.CC_W(CC_W)) u_cc (
        .clk   (clk),
        .rst   (rst),
        .we    (cc_we),
        .wdata (cc_wdata),
        .cc_q  (cc_q)
    );

    swcond_decode #(.NFLAG(NFLAG), .CC_W(CC_W)) u_sw (
        .clk    (clk),
        .rst    (rst),
        .cc_q   (cc_q),
        .sv     (stat.sv),
        .sgn    (stat.sgn),
        .flag   (flag_i),
        .sw_hit (sw_hit)
    );

    cond_fixed u_fix (
        .az     (stat.az),
        .an     (stat.an),
        .av     (stat.av),
        .ac     (stat.ac),
        .mv     (stat.mv),
        .sw_hit (sw_hit),
        .sel    (sel_eff),
        .result (cond_true)
    );

    // R1: the always code is true
    a_r1_always_true: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == SEL_ALWAYS) |-> cond_true);

    // R2: equal follows the zero bit, not-equal is its complement
    a_r2_eq_zero: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == SEL_EQ) |-> (cond_true == stat_i[0]));
    a_r2_ne_complement: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == SEL_NE) |-> (cond_true != stat_i[0]));

    // R6: the never code is false
    a_r6_never_false: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == SEL_NEVER) |-> !cond_true);

    // R7: the two software selectors give opposite answers
    a_r7_sw_polarity: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == SEL_NSW) |-> (cond_true == !sw_hit));

    // R8: a written shifter-overflow code applies on the next cycle
    a_r8_write_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cc_we) && ($past(cc_wdata) == CC_W'(CC_SV))
         && (cond_sel == SEL_SW)) |-> (cond_true == stat_i[5]));

endmodule

// File: tb/cond_eval_top_tb_top.sv
module cond_eval_top_tb_top;
    import cond_pkg::*;

    localparam int NFLAG = 4;
    localparam int CC_W  = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic [STAT_W-1:0] stat_i;
    logic [NFLAG-1:0]  flag_i;
    logic              cc_we;
    logic [CC_W-1:0]   cc_wdata;
    logic [SEL_W-1:0]  cond_sel;
    logic              cond_true;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;
    logic [CC_W-1:0] cc_model;

    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    cond_eval_top #(.NFLAG(NFLAG), .CC_W(CC_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .stat_i    (stat_i),
        .flag_i    (flag_i),
        .cc_we     (cc_we),
        .cc_wdata  (cc_wdata),
        .cond_sel  (cond_sel),
        .cond_true (cond_true)
    );

    // Reference built from the requirement text.
    function automatic bit ref_sw(input logic [CC_W-1:0] cc, input logic [6:0] s,
                                  input logic [NFLAG-1:0] f);
        if (cc == 5'h01) return s[6];
        if (cc == 5'h02) return !s[6];
        if (cc == 5'h09) return s[5];
        if (cc == 5'h0A) return !s[5];
        for (int i = 0; i < NFLAG; i++)
            if (cc == CC_W'(3 + i)) return f[i];
        return 1'b0;
    endfunction

    function automatic bit ref_eval(input logic r, input logic [3:0] sel,
                                    input logic [6:0] s, input logic [NFLAG-1:0] f,
                                    input logic [CC_W-1:0] cc);
        bit lt, gt;
        lt = s[1] ^ s[2];
        gt = !s[0] && !lt;
        if (r) return 1'b1;
        case (sel)
            4'd0:  return s[0];
            4'd1:  return !s[0];
            4'd2:  return gt;
            4'd3:  return !gt;
            4'd4:  return lt;
            4'd5:  return !lt;
            4'd6:  return s[2];
            4'd7:  return !s[2];
            4'd8:  return s[3];
            4'd9:  return !s[3];
            4'd10: return s[4];
            4'd11: return !s[4];
            4'd12: return ref_sw(cc, s, f);
            4'd13: return !ref_sw(cc, s, f);
            4'd14: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected answer.
    task automatic drive(input logic r, input logic [3:0] sel, input logic [6:0] s,
                         input logic [NFLAG-1:0] f, input logic we,
                         input logic [CC_W-1:0] wd, input string tag);
        @(negedge clk);
        rst      = r;
        cond_sel = sel;
        stat_i   = s;
        flag_i   = f;
        cc_we    = we;
        cc_wdata = wd;
        exp_q.push_back(ref_eval(r, sel, s, f, cc_model));
        tag_q.push_back(tag);
        if (r)       cc_model = '0;
        else if (we) cc_model = wd;
    endtask

    // Monitor: compares one queued item per cycle, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (cond_true !== e) begin
                    failures++;
                    $display("FAIL %s: cond_true=%0b expected=%0b (sel=%0d stat=%b flags=%b)",
                             t, cond_true, e, cond_sel, stat_i, flag_i);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cc_model = '0;
        rst = 1'b1; cond_sel = '0; stat_i = '0; flag_i = '0; cc_we = 1'b0; cc_wdata = '0;

        // R1: reset forces the always answer; R12: write during reset is dropped
        drive(1, 4'd0,  7'h00, 4'h0, 1, 5'h09, "R1 reset forces true");
        drive(1, 4'd14, 7'h00, 4'h0, 1, 5'h09, "R1 reset overrides never");
        drive(0, 4'd12, 7'h20, 4'h0, 0, 5'h00, "R12 reset code sw false");
        drive(0, 4'd13, 7'h20, 4'h0, 0, 5'h00, "R12 reset code inverse true");

        // R2 R3 R4 R5 R6 R1: fixed codes over all low status patterns
        for (int p = 0; p < 32; p++) begin
            for (int sel = 0; sel < 16; sel++) begin
                if (sel == 12 || sel == 13) continue;
                drive(0, 4'(sel), {2'b11, 5'(p)}, 4'hF, 0, 5'h00,
                      $sformatf("R2/R3/R4/R5/R6 fixed sel=%0d", sel));
            end
        end

        // R8: write 0x09, old code applies in the write cycle
        drive(0, 4'd12, 7'h20, 4'h0, 1, 5'h09, "R8 write cycle uses old code");
        drive(0, 4'd12, 7'h20, 4'h0, 0, 5'h00, "R8 new code next cycle");
        // R9: shifter overflow and its negation
        drive(0, 4'd12, 7'h00, 4'h0, 0, 5'h00, "R9 sv clear");
        drive(0, 4'd13, 7'h20, 4'h0, 0, 5'h00, "R7 inverse of sv");
        drive(0, 4'd6,  7'h20, 4'h0, 0, 5'h00, "R5 av ignores sv");
        drive(0, 4'd12, 7'h00, 4'h0, 1, 5'h0A, "R8 write 0x0A, old code");
        drive(0, 4'd12, 7'h00, 4'h0, 0, 5'h00, "R9 not-sv code with sv clear");
        drive(0, 4'd12, 7'h20, 4'h0, 0, 5'h00, "R9 not-sv code with sv set");

        // R10: flag codes, back-to-back writes
        drive(0, 4'd12, 7'h00, 4'h1, 1, 5'h03, "R8 write 0x03");
        for (int i = 0; i < NFLAG; i++) begin
            drive(0, 4'd12, 7'h00, 4'(1 << i), 1, 5'(4 + i), $sformatf("R10 flag%0d set", i));
            if (i + 1 < NFLAG)
                drive(0, 4'd12, 7'h00, ~4'(1 << (i + 1)), 0, 5'h00,
                      $sformatf("R10 flag%0d clear", i + 1));
        end
        drive(0, 4'd13, 7'h00, 4'hF, 0, 5'h00, "R12 code 0x07 inverse true");

        // R11: sign codes
        drive(0, 4'd12, 7'h40, 4'h0, 1, 5'h01, "R8 write 0x01");
        drive(0, 4'd12, 7'h40, 4'h0, 0, 5'h00, "R11 sign set");
        drive(0, 4'd12, 7'h00, 4'h0, 1, 5'h02, "R11 sign clear code 1");
        drive(0, 4'd12, 7'h00, 4'h0, 0, 5'h00, "R11 not-sign, sign clear");
        drive(0, 4'd12, 7'h40, 4'h0, 0, 5'h00, "R11 not-sign, sign set");

        // R12: unassigned codes
        drive(0, 4'd12, 7'h7F, 4'hF, 1, 5'h1F, "R12 write 0x1F");
        drive(0, 4'd12, 7'h7F, 4'hF, 0, 5'h00, "R12 unassigned sw false");
        drive(0, 4'd13, 7'h7F, 4'hF, 0, 5'h00, "R12 unassigned inverse true");

        // R12: reset returns the code to 0x00
        drive(1, 4'd12, 7'h7F, 4'hF, 0, 5'h00, "R1 reset true");
        drive(0, 4'd12, 7'h7F, 4'hF, 0, 5'h00, "R12 code cleared by reset");
        drive(0, 4'd15, 7'h00, 4'h0, 0, 5'h00, "R1 always");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule